// File: doc/BRIEF.md
# Receive Status Delay Pipeline

This block decides when the receive-side indicators of one serial channel become visible to the host. Each completed character arrives as a one-cycle pulse that carries its parity, framing and break flags. The block holds it for a number of cycles that depends on the mode, then publishes it as data-ready, error flags and overrun. With the FIFO disabled, a character is published one cycle after it arrives. With the FIFO enabled, it is published three cycles after it arrives. Once the host has begun reading, a read of the data register publishes the oldest held character at once.

A separate filter watches the FIFO fill level against a selectable threshold. It raises or drops the trigger interrupt only after the new condition has held for eight consecutive cycles. The receive-ready request follows data-ready without the FIFO. With the FIFO, it waits for the trigger and then stays up until the data drains. Every cycle of `clk` is one receiver timing cycle. The character storage and the deserializer sit outside the block and feed the fill level and the character pulses.

Top module: `rx_status_delay`

## Requirements
- R1: In reset, and on the first cycle after it, every output is 0.
- R2: With `fifo_en` low, a `char_done` sampled at clock edge N is shown on `data_ready`, the error flags and `overrun` after edge N+1.
- R3: With `fifo_en` high, a `char_done` sampled at edge N is shown after edge N+3 and not earlier, unless R5 applies.
- R4: Characters arriving in consecutive cycles are each published, one per cycle, in arrival order. None is lost. Each one adds to the unread count.
- R5: After the first character since reset has been published, an `rd_data` pulse at an edge publishes the oldest held character at that same edge. Before that first publication, `rd_data` does not speed anything up.
- R6: `err_pe`, `err_fe`, `err_bi` and `overrun` are sticky. An `rd_status` pulse clears them at the next edge. If a character is published at that same edge, the published flags survive.
- R7: A character is marked overrun when it arrives in either of two cases. With the FIFO disabled, the case is while an earlier character is still held or unread. With the FIFO enabled, the case is while `fifo_level` equals FIFO_DEPTH. The mark is shown with the same delay as the character.
- R8: `data_ready` is high while the count of published, unread characters is nonzero. The count is capped at 1 without the FIFO and at FIFO_DEPTH with it. `rd_data` lowers the count by one, and a read at zero is ignored. `irq_data` equals `data_ready` with the FIFO disabled and is 0 with it enabled.
- R9: The trigger condition is `fifo_en` high and `fifo_level` at or above the threshold selected by `trig_sel`. The codes are 0 for 1 byte, 1 for 4, 2 for 8 and 3 for 14.
- R10: `irq_trig` takes a new value of the trigger condition only at the 8th consecutive edge at which that new value is sampled. A shorter excursion leaves `irq_trig` unchanged.
- R11: `rx_ready` equals `data_ready` with the FIFO disabled. With the FIFO enabled, it rises when `irq_trig` and `data_ready` are both high, then holds until `data_ready` falls.
- R12: `irq_status` is high while any error flag or `overrun` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | receiver timing clock |
| rst | input | 1 | synchronous reset, active high |
| char_done | input | 1 | one-cycle pulse: a character has been assembled |
| char_pe | input | 1 | parity error of that character |
| char_fe | input | 1 | framing error of that character |
| char_bi | input | 1 | break seen on that character |
| rd_data | input | 1 | host reads the receive data register |
| rd_status | input | 1 | host reads the line status register |
| fifo_en | input | 1 | FIFO mode enable |
| trig_sel | input | 2 | trigger threshold select |
| fifo_level | input | LVL_W | current FIFO fill level |
| data_ready | output | 1 | unread data is available |
| overrun | output | 1 | sticky overrun flag |
| err_pe | output | 1 | sticky parity error |
| err_fe | output | 1 | sticky framing error |
| err_bi | output | 1 | sticky break indication |
| irq_data | output | 1 | data-available interrupt, used without the FIFO |
| irq_status | output | 1 | line-status interrupt |
| irq_trig | output | 1 | filtered trigger-level interrupt |
| rx_ready | output | 1 | receive-ready request for a DMA engine |

## Verification
The bench checks the exact publication cycle in both modes. A design that is off by one register would show flags a cycle early or late. It sends three characters back to back in FIFO mode and reads the accumulated flags one cycle at a time. This exposes a design that drops or reorders an event inside the delay window, or that needs fewer than three reads to drain. It checks that a data read publishes a held character at once after the first publication but not before it, which catches a bypass that is always on or never on. It moves the fill level across each threshold code, including excursions shorter than eight cycles, so a filter that does not restart its count, or that counts one cycle too few, gives a wrong edge.

// File: rtl/rsdp_pkg.sv
package rsdp_pkg;

    // One received character's status, carried through the delay queue.
    typedef struct packed {
        logic ovr;
        logic bi;
        logic fe;
        logic pe;
    } rx_evt_t;

    localparam int TRIG_SEL_W = 2;

    // Threshold in bytes for each trigger select code.
    function automatic int trig_bytes(input logic [TRIG_SEL_W-1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rsdp_evt_queue.sv
// Holds arrived characters in order. Each entry carries its own countdown.
// Only the head may leave, either when its countdown is spent or on a bypass.
module rsdp_evt_queue
    import rsdp_pkg::*;
#(
    parameter int QDEPTH   = 4,
    parameter int FIFO_DLY = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  rx_evt_t push_evt,
    input  logic    fifo_en,
    input  logic    bypass_req,
    output logic    rel,
    output rx_evt_t rel_evt,
    output logic    busy
);
    localparam int TW = $clog2(FIFO_DLY + 1);
    localparam logic [TW-1:0] LOAD_FIFO = TW'(FIFO_DLY - 1);

    logic [QDEPTH-1:0] vld_q;
    rx_evt_t           evt_q [QDEPTH];
    logic [TW-1:0]     tmr_q [QDEPTH];

    logic [QDEPTH-1:0] sh_vld;
    rx_evt_t           sh_evt [QDEPTH];
    logic [TW-1:0]     sh_tmr [QDEPTH];

    logic [QDEPTH-1:0] vld_d;
    rx_evt_t           evt_d [QDEPTH];
    logic [TW-1:0]     tmr_d [QDEPTH];

    assign rel     = vld_q[0] && ((tmr_q[0] == '0) || bypass_req);
    assign rel_evt = evt_q[0];
    assign busy    = |vld_q;

    // Slot g takes slot g+1 when the head leaves.
    for (genvar g = 0; g < QDEPTH; g++) begin : g_shift
        if (g < QDEPTH - 1) begin : g_mid
            assign sh_vld[g] = rel ? vld_q[g+1] : vld_q[g];
            assign sh_evt[g] = rel ? evt_q[g+1] : evt_q[g];
            assign sh_tmr[g] = rel ? tmr_q[g+1] : tmr_q[g];
        end else begin : g_last
            assign sh_vld[g] = rel ? 1'b0 : vld_q[g];
            assign sh_evt[g] = rel ? rx_evt_t'('0) : evt_q[g];
            assign sh_tmr[g] = rel ? '0 : tmr_q[g];
        end
    end

    always_comb begin
        logic placed;
        placed = 1'b0;
        for (int i = 0; i < QDEPTH; i++) begin
            vld_d[i] = sh_vld[i];
            evt_d[i] = sh_evt[i];
            tmr_d[i] = (sh_tmr[i] != '0) ? sh_tmr[i] - 1'b1 : '0;
            if (push && !placed && !sh_vld[i]) begin
                vld_d[i] = 1'b1;
                evt_d[i] = push_evt;
                tmr_d[i] = fifo_en ? LOAD_FIFO : '0;
                placed   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < QDEPTH; i++) begin
                evt_q[i] <= rx_evt_t'('0);
                tmr_q[i] <= '0;
            end
        end else begin
            vld_q <= vld_d;
            for (int i = 0; i < QDEPTH; i++) begin
                evt_q[i] <= evt_d[i];
                tmr_q[i] <= tmr_d[i];
            end
        end
    end

endmodule

// File: rtl/rsdp_trig_filter.sv
// Trigger-level condition with a persistence filter of TRIG_DLY cycles.
module rsdp_trig_filter
    import rsdp_pkg::*;
#(
    parameter int LVL_W    = 5,
    parameter int TRIG_DLY = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fifo_en,
    input  logic [TRIG_SEL_W-1:0] trig_sel,
    input  logic [LVL_W-1:0]      fifo_level,
    output logic                  irq_trig
);
    localparam int CW = $clog2(TRIG_DLY + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TRIG_DLY - 1);

    logic          met;
    logic [CW-1:0] cnt_q;

    assign met = fifo_en && (int'(fifo_level) >= trig_bytes(trig_sel));

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_trig <= 1'b0;
            cnt_q    <= '0;
        end else if (met != irq_trig) begin
            if (cnt_q == CNT_LAST) begin
                irq_trig <= met;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/rsdp_status_regs.sv
// Host-visible state: unread count, sticky flags, request hold.
module rsdp_status_regs
    import rsdp_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W      = 5
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    rel,
    input  rx_evt_t rel_evt,
    input  logic    rd_data,
    input  logic    rd_status,
    input  logic    fifo_en,
    input  logic    irq_trig,
    output logic    data_ready,
    output logic    overrun,
    output logic    err_pe,
    output logic    err_fe,
    output logic    err_bi,
    output logic    irq_data,
    output logic    irq_status,
    output logic    rx_ready,
    output logic    first_seen
);
    logic [LVL_W-1:0] avail_q;
    logic [LVL_W-1:0] after_rd;
    logic [LVL_W-1:0] cap;
    rx_evt_t          flags_q;
    rx_evt_t          flag_base;
    logic             hold_q;

    assign cap       = fifo_en ? LVL_W'(FIFO_DEPTH) : LVL_W'(1);
    assign after_rd  = (rd_data && (avail_q != '0)) ? avail_q - 1'b1 : avail_q;
    assign flag_base = rd_status ? rx_evt_t'('0) : flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            avail_q    <= '0;
            flags_q    <= rx_evt_t'('0);
            first_seen <= 1'b0;
            hold_q     <= 1'b0;
        end else begin
            avail_q    <= (rel && (after_rd < cap)) ? after_rd + 1'b1 : after_rd;
            first_seen <= first_seen | rel;
            hold_q     <= fifo_en && (hold_q || irq_trig) && data_ready;
            if (rel) begin
                flags_q <= rx_evt_t'(flag_base | rel_evt);
            end else if (rd_status) begin
                flags_q <= rx_evt_t'('0);
            end
        end
    end

    assign data_ready = (avail_q != '0);
    assign overrun    = flags_q.ovr;
    assign err_pe     = flags_q.pe;
    assign err_fe     = flags_q.fe;
    assign err_bi     = flags_q.bi;
    assign irq_data   = data_ready && !fifo_en;
    assign irq_status = |flags_q;
    assign rx_ready   = fifo_en ? ((hold_q || irq_trig) && data_ready) : data_ready;

endmodule

// File: rtl/rx_status_delay.sv
module rx_status_delay
    import rsdp_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int QDEPTH     = 4,
    parameter int FIFO_DLY   = 3,
    parameter int TRIG_DLY   = 8,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  char_done,
    input  logic                  char_pe,
    input  logic                  char_fe,
    input  logic                  char_bi,
    input  logic                  rd_data,
    input  logic                  rd_status,
    input  logic                  fifo_en,
    input  logic [TRIG_SEL_W-1:0] trig_sel,
    input  logic [LVL_W-1:0]      fifo_level,
    output logic                  data_ready,
    output logic                  overrun,
    output logic                  err_pe,
    output logic                  err_fe,
    output logic                  err_bi,
    output logic                  irq_data,
    output logic                  irq_status,
    output logic                  irq_trig,
    output logic                  rx_ready
);
    rx_evt_t in_evt;
    rx_evt_t q_evt;
    logic    q_rel;
    logic    q_busy;
    logic    first_seen;
    logic    ovr_in;

    // Overrun is judged when the character arrives.
    assign ovr_in = fifo_en ? (fifo_level == LVL_W'(FIFO_DEPTH))
                            : (data_ready || q_busy);
    assign in_evt = '{ovr: ovr_in, bi: char_bi, fe: char_fe, pe: char_pe};

    rsdp_evt_queue #(
        .QDEPTH   (QDEPTH),
        .FIFO_DLY (FIFO_DLY)
    ) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push       (char_done),
        .push_evt   (in_evt),
        .fifo_en    (fifo_en),
        .bypass_req (rd_data && first_seen),
        .rel        (q_rel),
        .rel_evt    (q_evt),
        .busy       (q_busy)
    );

    rsdp_trig_filter #(
        .LVL_W    (LVL_W),
        .TRIG_DLY (TRIG_DLY)
    ) u_trig (
        .clk        (clk),
        .rst        (rst),
        .fifo_en    (fifo_en),
        .trig_sel   (trig_sel),
        .fifo_level (fifo_level),
        .irq_trig   (irq_trig)
    );

    rsdp_status_regs #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .LVL_W      (LVL_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .rel        (q_rel),
        .rel_evt    (q_evt),
        .rd_data    (rd_data),
        .rd_status  (rd_status),
        .fifo_en    (fifo_en),
        .irq_trig   (irq_trig),
        .data_ready (data_ready),
        .overrun    (overrun),
        .err_pe     (err_pe),
        .err_fe     (err_fe),
        .err_bi     (err_bi),
        .irq_data   (irq_data),
        .irq_status (irq_status),
        .rx_ready   (rx_ready),
        .first_seen (first_seen)
    );

endmodule

// File: rtl/rsdp_checker.sv
module rsdp_checker
    import rsdp_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  char_done,
    input logic                  rd_status,
    input logic                  fifo_en,
    input logic [TRIG_SEL_W-1:0] trig_sel,
    input logic [LVL_W-1:0]      fifo_level,
    input logic                  data_ready,
    input logic                  overrun,
    input logic                  err_pe,
    input logic                  err_fe,
    input logic                  err_bi,
    input logic                  irq_status,
    input logic                  irq_trig,
    input logic                  q_rel
);
    logic met;
    assign met = fifo_en && (int'(fifo_level) >= trig_bytes(trig_sel));

    assert_nofifo_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (char_done && !fifo_en) ##1 !fifo_en |=> data_ready);

    assert_flags_via_release_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(err_pe) || $rose(err_fe) || $rose(err_bi) || $rose(overrun)) |-> $past(q_rel));

    assert_status_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !q_rel) |=> !irq_status);

    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (overrun && !rd_status) |=> overrun);

    assert_ready_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(data_ready) |-> $past(q_rel));

    assert_trig_persist_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_trig) |-> ($past(met) && $past(met, 2)));

endmodule

bind rx_status_delay rsdp_checker #(.LVL_W(LVL_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .char_done  (char_done),
    .rd_status  (rd_status),
    .fifo_en    (fifo_en),
    .trig_sel   (trig_sel),
    .fifo_level (fifo_level),
    .data_ready (data_ready),
    .overrun    (overrun),
    .err_pe     (err_pe),
    .err_fe     (err_fe),
    .err_bi     (err_bi),
    .irq_status (irq_status),
    .irq_trig   (irq_trig),
    .q_rel      (q_rel)
);

// File: tb/test_rx_status_delay.sv
`timescale 1ns/1ps
module test_rx_status_delay;
    localparam int DEPTH = 16;
    localparam int LW    = $clog2(DEPTH + 1);
    localparam int K_RBR = 0;
    localparam int K_LSR = 1;
    localparam int K_REL = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic char_done = 1'b0, char_pe = 1'b0, char_fe = 1'b0, char_bi = 1'b0;
    logic rd_data = 1'b0, rd_status = 1'b0, fifo_en = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic [LW-1:0] fifo_level = '0;
    logic data_ready, overrun, err_pe, err_fe, err_bi;
    logic irq_data, irq_status, irq_trig, rx_ready;

    always #10 clk = ~clk;

    rx_status_delay #(.FIFO_DEPTH(DEPTH)) i_rx_status_delay (
        .clk(clk), .rst(rst), .char_done(char_done), .char_pe(char_pe),
        .char_fe(char_fe), .char_bi(char_bi), .rd_data(rd_data),
        .rd_status(rd_status), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .fifo_level(fifo_level), .data_ready(data_ready), .overrun(overrun),
        .err_pe(err_pe), .err_fe(err_fe), .err_bi(err_bi), .irq_data(irq_data),
        .irq_status(irq_status), .irq_trig(irq_trig), .rx_ready(rx_ready)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic mon_en = 1'b0;
    string cur_req = "R2";

    typedef struct {
        int due;
        int kind;
        logic [3:0] f;   // {ovr, bi, fe, pe}
    } sb_t;
    sb_t sb[$];
    int m_avail = 0;
    logic [3:0] m_flags = 4'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Monitor: retire scoreboard items that fall due, then compare the ports.
    always @(negedge clk) begin
        if (mon_en) begin
            for (int pass = 0; pass < 3; pass++) begin
                int k;
                k = 0;
                while (k < sb.size()) begin
                    if (sb[k].due == cyc && sb[k].kind == pass) begin
                        if (pass == K_RBR && m_avail > 0) m_avail--;
                        if (pass == K_LSR) m_flags = 4'b0;
                        if (pass == K_REL) begin
                            m_flags = m_flags | sb[k].f;
                            if (m_avail < (fifo_en ? DEPTH : 1)) m_avail++;
                        end
                        sb.delete(k);
                    end else begin
                        k++;
                    end
                end
            end
            chk(cur_req, "data_ready", int'(data_ready), int'(m_avail != 0));
            chk(cur_req, "err_pe", int'(err_pe), int'(m_flags[0]));
            chk(cur_req, "err_fe", int'(err_fe), int'(m_flags[1]));
            chk(cur_req, "err_bi", int'(err_bi), int'(m_flags[2]));
            chk(cur_req, "overrun", int'(overrun), int'(m_flags[3]));
            chk("R12", "irq_status", int'(irq_status), int'(m_flags != 4'b0));
            chk("R8", "irq_data", int'(irq_data), int'((m_avail != 0) && !fifo_en));
            if (!fifo_en) chk("R11", "rx_ready", int'(rx_ready), int'(m_avail != 0));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic pe, input logic fe, input logic bi, input logic ovr);
        int d;
        d = fifo_en ? 3 : 1;
        char_done = 1'b1; char_pe = pe; char_fe = fe; char_bi = bi;
        sb.push_back('{due: cyc + 1 + d, kind: K_REL, f: {ovr, bi, fe, pe}});
        @(negedge clk);
        char_done = 1'b0; char_pe = 1'b0; char_fe = 1'b0; char_bi = 1'b0;
    endtask

    task automatic rd_rbr();
        rd_data = 1'b1;
        sb.push_back('{due: cyc + 1, kind: K_RBR, f: 4'b0});
        @(negedge clk);
        rd_data = 1'b0;
    endtask

    task automatic rd_lsr();
        rd_status = 1'b1;
        sb.push_back('{due: cyc + 1, kind: K_LSR, f: 4'b0});
        @(negedge clk);
        rd_status = 1'b0;
    endtask

    task automatic do_reset();
        mon_en = 1'b0;
        rst = 1'b1;
        char_done = 1'b0; rd_data = 1'b0; rd_status = 1'b0;
        fifo_en = 1'b0; trig_sel = 2'd0; fifo_level = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        sb.delete();
        m_avail = 0;
        m_flags = 4'b0;
        @(negedge clk);
    endtask

    // Hold the level for n edges and check the filtered output at the end.
    task automatic trig_step(input int lvl, input int n, input logic exp, input string what);
        fifo_level = LW'(lvl);
        idle(n);
        chk("R10", what, int'(irq_trig), int'(exp));
    endtask

    initial begin
        do_reset();
        // R1: everything low right after reset
        chk("R1", "outputs after reset",
            int'({data_ready, overrun, err_pe, err_fe, err_bi, irq_data, irq_status, irq_trig, rx_ready}), 0);

        // R2, R6, R8: FIFO disabled, one-cycle publication, sticky flags, reads
        mon_en = 1'b1;
        cur_req = "R2";
        send(1'b1, 1'b0, 1'b0, 1'b0);
        idle(3);
        cur_req = "R6";
        rd_lsr();
        idle(1);
        cur_req = "R8";
        rd_rbr();
        idle(1);
        rd_rbr();           // read with nothing unread is ignored
        idle(2);

        // R7: second character while the first is still held
        cur_req = "R7";
        send(1'b0, 1'b0, 1'b0, 1'b0);
        send(1'b0, 1'b1, 1'b0, 1'b1);
        idle(3);
        rd_rbr();
        idle(1);
        rd_lsr();
        idle(2);

        // R3, R4: FIFO mode, three characters back to back
        fifo_en = 1'b1;
        idle(2);
        cur_req = "R4";
        send(1'b0, 1'b0, 1'b1, 1'b0);
        send(1'b1, 1'b0, 1'b0, 1'b0);
        send(1'b0, 1'b1, 1'b0, 1'b0);
        idle(5);
        cur_req = "R3";
        rd_rbr();
        idle(1);
        rd_rbr();
        idle(1);
        rd_rbr();
        idle(1);
        rd_lsr();
        idle(2);

        // R7: FIFO full at arrival
        cur_req = "R7";
        fifo_level = LW'(DEPTH);
        send(1'b0, 1'b0, 1'b0, 1'b1);
        fifo_level = '0;
        idle(4);
        rd_lsr();
        rd_rbr();
        idle(2);
        mon_en = 1'b0;

        // R5: a read publishes the held character at once after the first publication
        char_done = 1'b1; char_pe = 1'b1;
        @(negedge clk);
        char_done = 1'b0; char_pe = 1'b0; rd_data = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
        chk("R5", "err_pe on bypass", int'(err_pe), 1);
        chk("R5", "data_ready on bypass", int'(data_ready), 1);
        rd_status = 1'b1; rd_data = 1'b1;
        @(negedge clk);
        rd_status = 1'b0; rd_data = 1'b0;
        @(negedge clk);
        chk("R6", "flags cleared by status read", int'({err_pe, irq_status}), 0);

        // R5, R3: no bypass before the first publication after reset
        do_reset();
        fifo_en = 1'b1;
        char_done = 1'b1; char_pe = 1'b1;
        @(negedge clk);
        char_done = 1'b0; char_pe = 1'b0; rd_data = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
        chk("R5", "no bypass before first byte", int'(err_pe), 0);
        @(negedge clk);
        chk("R3", "err_pe not yet at +2", int'(err_pe), 0);
        chk("R3", "data_ready not yet at +2", int'(data_ready), 0);
        @(negedge clk);
        chk("R3", "err_pe at +3", int'(err_pe), 1);
        chk("R3", "data_ready at +3", int'(data_ready), 1);

        // R9, R10: trigger filter
        do_reset();
        fifo_en = 1'b1;
        trig_sel = 2'd1;
        trig_step(4, 7, 1'b0, "R9 level 4 code 1, 7 edges");
        idle(1);
        chk("R9", "level 4 code 1 after 8 edges", int'(irq_trig), 1);
        trig_step(3, 7, 1'b1, "drop held 7 edges");
        idle(1);
        chk("R10", "drop after 8 edges", int'(irq_trig), 0);
        trig_step(4, 3, 1'b0, "short excursion 3 edges");
        trig_step(3, 12, 1'b0, "short excursion ignored");
        trig_sel = 2'd3;
        trig_step(13, 10, 1'b0, "R9 level 13 code 3");
        trig_step(14, 8, 1'b1, "R9 level 14 code 3");
        trig_step(0, 8, 1'b0, "R9 level 0 code 3");
        trig_sel = 2'd0;
        trig_step(1, 8, 1'b1, "R9 level 1 code 0");
        fifo_en = 1'b0;
        trig_step(DEPTH, 8, 1'b0, "R9 no trigger without FIFO");

        // R11: request waits for the trigger, then holds until drained
        do_reset();
        fifo_en = 1'b1;
        trig_sel = 2'd2;
        char_done = 1'b1;
        @(negedge clk);
        char_done = 1'b0;
        idle(4);
        chk("R11", "no request before trigger", int'(rx_ready), 0);
        chk("R8", "irq_data quiet in FIFO mode", int'(irq_data), 0);
        fifo_level = LW'(8);
        idle(8);
        chk("R11", "request with trigger", int'(rx_ready), 1);
        fifo_level = '0;
        idle(9);
        chk("R11", "trigger gone", int'(irq_trig), 0);
        chk("R11", "request held", int'(rx_ready), 1);
        rd_data = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
        chk("R11", "request drops when drained", int'(rx_ready), 0);
        idle(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule